// File: doc/BRIEF.md
# External Interrupt Pin Sense Unit

This block turns up to six asynchronous external interrupt pins into clean interrupt requests for the rest of the chip. Each pin first passes through a synchronizer. A small per-pin mode selects how the pin is read: as an active-low level, an active-high level, a rising edge, a falling edge, or any edge. Edge events are held in a request flop until software acknowledges them. Level requests simply follow the synchronized pin.

A per-pin mask gates each request onto its output line. The outputs can drive dedicated processor interrupt inputs or a range of source bits of a main interrupt controller; that choice is made outside this block.

Software reaches all pin controls through 32-bit configuration words, with four pins per word. Word 0 holds pins 0 to 3 and word 1 holds pins 4 and up. Writes apply in one cycle. Reads are combinational from the selected word. There is no streaming data path, so every pin is a plain control or status signal.

Top module: `ext_irq_sense`

## Requirements
- R1: While reset is asserted and after it is released, every pin is in active-low level mode (level-sense 1, sense 0, both-edge 0), every mask is 0, and `irq_o` is all zero.
- R2: Pin p is controlled by word p/4 at slot s = p%4. In that word: request status is bit s, acknowledge is bit 4+s, mask is bit 8+s, sense is bit 12+s, both-edge is bit 16+s, level-sense is bit 20+s. Bits 31:24 read 0.
- R3: With level-sense 0, both-edge 0 and sense 1, a low-to-high transition of the synchronized pin sets the pin's request, and a high-to-low transition does not.
- R4: With level-sense 0, both-edge 0 and sense 0, a high-to-low transition sets the request, and a low-to-high transition does not.
- R5: With level-sense 0 and both-edge 1, either transition sets the request.
- R6: In the edge modes, a request stays set until a write puts 1 in its acknowledge bit, which clears it. Acknowledge bits always read 0.
- R7: If an edge event and an acknowledge of the same pin occur in the same cycle, the request stays set.
- R8: With level-sense 1, the request equals the synchronized pin when sense is 1, and its inverse when sense is 0. The acknowledge bit has no effect in this mode.
- R9: `irq_o[p]` is the pin's request ANDed with its mask. The status bit shows the request whatever the mask.
- R10: A pin change that is present before clock edge k shows in the status and `irq_o` after edge k+2, and not before.
- R11: Slots of a word that map to pins at or above NPINS read 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin_i | input | NPINS | Asynchronous external interrupt pins |
| cfg_we | input | 1 | Write strobe for the selected configuration word |
| cfg_sel | input | SEL_W | Configuration word select (0: pins 0-3, 1: pins 4+) |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data of the selected word |
| irq_o | output | NPINS | Masked interrupt requests, one per pin |

## Verification
The embedded assertions check on every cycle that:
- an edge request holds until it is acknowledged;
- a request rises in edge mode only after a synchronized transition;
- a level request tracks the pin;
- an edge event beats a simultaneous acknowledge;
- acknowledge bits and unpopulated slots read zero.

Only the bench scenarios can show the following:
- the exact two-edge latency from pin to output;
- that each mode ignores the opposite transition;
- that the mask gates the output while status stays visible;
- that writes are routed to the right word and slot, including the second word for the upper pins.

// File: rtl/ext_sense_pkg.sv
package ext_sense_pkg;
  localparam int PPR     = 4;   // pins per configuration word
  localparam int STAT_OFS = 0;
  localparam int ACK_OFS  = 4;
  localparam int MSK_OFS  = 8;
  localparam int SNS_OFS  = 12;
  localparam int BTH_OFS  = 16;
  localparam int LVL_OFS  = 20;

  typedef struct packed {
    logic lvl;    // 1: level mode
    logic sense;  // polarity / edge direction
    logic both;   // any edge
    logic mask;   // output enable
  } pin_cfg_t;
endpackage

// File: rtl/ext_sync_2ff.sv
module ext_sync_2ff #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/ext_pin_sense.sv
module ext_pin_sense
  import ext_sense_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     pin_i,
  input  pin_cfg_t cfg_i,
  input  logic     ack_i,
  output logic     req_o
);
  logic sync, prev_q, req_q;
  logic rise, fall, hit, lvl_act, req_d;

  ext_sync_2ff #(.W(1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_i(pin_i), .q_o(sync)
  );

  always_comb begin
    rise    = sync & ~prev_q;
    fall    = ~sync & prev_q;
    hit     = cfg_i.both ? (rise | fall) : (cfg_i.sense ? rise : fall);
    lvl_act = cfg_i.sense ? sync : ~sync;
    req_d   = cfg_i.lvl ? lvl_act : ((req_q & ~ack_i) | hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
      req_q  <= 1'b0;
    end else begin
      prev_q <= sync;
      req_q  <= req_d;
    end
  end

  assign req_o = req_q;

  AST_EDGE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.lvl && req_q && !ack_i) |=> req_q); // R6
  AST_EDGE_NEEDS_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.lvl && !req_q) |=> (!req_q || $past(sync != prev_q))); // R3
  AST_LEVEL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_i.lvl |=> (req_q == ($past(cfg_i.sense) ? $past(sync) : !$past(sync)))); // R8
  AST_SET_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_i.lvl && !cfg_i.both && cfg_i.sense && ack_i && sync && !prev_q) |=> req_q); // R7
endmodule

// File: rtl/ext_cfg_regs.sv
module ext_cfg_regs
  import ext_sense_pkg::*;
#(
  parameter int NPINS = 6,
  parameter int SEL_W = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we_i,
  input  logic [SEL_W-1:0]       sel_i,
  input  logic [31:0]            wdata_i,
  input  logic [NPINS-1:0]       req_i,
  output pin_cfg_t [NPINS-1:0]   cfg_o,
  output logic [NPINS-1:0]       ack_o,
  output logic [31:0]            rdata_o
);
  logic unused_hi;
  assign unused_hi = ^wdata_i[31:24];

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    localparam int WRD  = p / PPR;
    localparam int SLOT = p % PPR;
    logic hit_word;
    assign hit_word = we_i && (sel_i == SEL_W'(WRD));
    assign ack_o[p] = hit_word && wdata_i[ACK_OFS+SLOT];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cfg_o[p] <= '{lvl: 1'b1, sense: 1'b0, both: 1'b0, mask: 1'b0};
      end else if (hit_word) begin
        cfg_o[p].mask  <= wdata_i[MSK_OFS+SLOT];
        cfg_o[p].sense <= wdata_i[SNS_OFS+SLOT];
        cfg_o[p].both  <= wdata_i[BTH_OFS+SLOT];
        cfg_o[p].lvl   <= wdata_i[LVL_OFS+SLOT];
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int p = 0; p < NPINS; p++) begin
      if (sel_i == SEL_W'(p / PPR)) begin
        rdata_o[STAT_OFS + p % PPR] = req_i[p];
        rdata_o[MSK_OFS  + p % PPR] = cfg_o[p].mask;
        rdata_o[SNS_OFS  + p % PPR] = cfg_o[p].sense;
        rdata_o[BTH_OFS  + p % PPR] = cfg_o[p].both;
        rdata_o[LVL_OFS  + p % PPR] = cfg_o[p].lvl;
      end
    end
  end

  always_comb begin
    if (rst_n) begin
      AST_ACK_READS_ZERO: assert (rdata_o[ACK_OFS +: PPR] == '0); // R6
      AST_HIGH_BITS_ZERO: assert (rdata_o[31:24] == '0); // R2
    end
  end

  always_comb begin
    if (rst_n) begin
      for (int s = 0; s < PPR; s++) begin
        if (int'(sel_i) * PPR + s >= NPINS) begin
          AST_EMPTY_SLOT_ZERO: assert (!rdata_o[STAT_OFS+s] && !rdata_o[MSK_OFS+s]
            && !rdata_o[SNS_OFS+s] && !rdata_o[BTH_OFS+s] && !rdata_o[LVL_OFS+s]); // R11
        end
      end
    end
  end
endmodule

// File: rtl/ext_irq_sense.sv
module ext_irq_sense
  import ext_sense_pkg::*;
#(
  parameter int NPINS = 6,
  localparam int NWORDS = (NPINS + PPR - 1) / PPR,
  localparam int SEL_W  = (NWORDS > 1) ? $clog2(NWORDS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPINS-1:0] ext_pin_i,
  input  logic             cfg_we,
  input  logic [SEL_W-1:0] cfg_sel,
  input  logic [31:0]      cfg_wdata,
  output logic [31:0]      cfg_rdata,
  output logic [NPINS-1:0] irq_o
);
  pin_cfg_t [NPINS-1:0] cfg;
  logic [NPINS-1:0]     ack;
  logic [NPINS-1:0]     req;

  ext_cfg_regs #(.NPINS(NPINS), .SEL_W(SEL_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we), .sel_i(cfg_sel),
    .wdata_i(cfg_wdata), .req_i(req), .cfg_o(cfg), .ack_o(ack),
    .rdata_o(cfg_rdata)
  );

  for (genvar p = 0; p < NPINS; p++) begin : g_pin
    ext_pin_sense u_pin (
      .clk(clk), .rst_n(rst_n), .pin_i(ext_pin_i[p]), .cfg_i(cfg[p]),
      .ack_i(ack[p]), .req_o(req[p])
    );
    assign irq_o[p] = req[p] & cfg[p].mask;
  end
endmodule

// File: tb/tb_ext_irq_sense.sv
`timescale 1ns/1ps
module tb_ext_irq_sense;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [5:0]  pins = '0;
  logic        we = 0;
  logic [0:0]  sel = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [5:0]  irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  typedef struct { logic [5:0] irq; string tag; } exp_t;
  exp_t q[$];
  exp_t e;

  always #2.5 clk = ~clk;

  ext_irq_sense #(.NPINS(6)) dut (
    .clk(clk), .rst_n(rst_n), .ext_pin_i(pins), .cfg_we(we), .cfg_sel(sel),
    .cfg_wdata(wdata), .cfg_rdata(rdata), .irq_o(irq)
  );

  // monitor: pop one expected item per falling edge and compare
  always @(negedge clk) begin
    if (q.size() > 0) begin
      e = q.pop_front();
      n_chk++;
      if (irq !== e.irq) begin
        n_fail++;
        $display("FAIL %s: irq_o actual %h expected %h", e.tag, irq, e.irq);
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(input logic [5:0] v, input string tag);
    exp_t it;
    it.irq = v;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic wr(input logic [0:0] s, input logic [31:0] d);
    sel = s; wdata = d; we = 1;
    tick(1);
    we = 0;
  endtask

  task automatic rd_check(input logic [0:0] s, input logic [31:0] exp, input string tag);
    sel = s;
    #1;
    n_chk++;
    if (rdata !== exp) begin
      n_fail++;
      $display("FAIL %s: cfg_rdata actual %h expected %h", tag, rdata, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      n_fail++;
      n_chk++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  localparam logic [31:0] CFG0 = 32'h0084_9F00;

  initial begin
    tick(3);
    rst_n = 1;
    tick(3);
    push(6'h00, "R1 reset outputs");
    rd_check(0, 32'h00F0_000F, "R1 R2 word0 default");
    rd_check(1, 32'h0030_0003, "R1 R11 word1 default");

    // pin0 rising, pin1 falling, pin2 both, pin3 level high, all masked in
    wr(0, CFG0);
    wr(0, CFG0 | 32'h70);
    push(6'h00, "R6 flush by acknowledge");
    rd_check(0, CFG0, "R6 R2 acknowledge reads zero");

    pins[3:0] = 4'hF;
    tick(2);
    push(6'h00, "R10 not visible after two edges");
    tick(1);
    push(6'h0D, "R3 R5 R8 R10 raise");

    pins[3:0] = 4'h0;
    tick(3);
    push(6'h07, "R4 R6 fall latched and rise held");

    wr(0, CFG0 | 32'h30);
    push(6'h04, "R6 acknowledge clears");

    pins[3] = 1;
    tick(3);
    push(6'h0C, "R8 level high");
    wr(0, CFG0 | 32'h80);
    push(6'h0C, "R8 acknowledge ignored in level");
    pins[3] = 0;
    tick(3);
    push(6'h04, "R8 level drop");

    pins[0] = 1;
    tick(2);
    wr(0, CFG0 | 32'h10);
    push(6'h05, "R7 edge beats acknowledge");
    tick(1);
    push(6'h05, "R7 request held");

    wr(0, 32'h0084_9B00);
    push(6'h01, "R9 mask gates output");
    rd_check(0, 32'h0084_9B05, "R9 status ignores mask");

    wr(1, 32'h0060_5F00);
    wr(1, 32'h0060_5F10);
    push(6'h21, "R2 R11 upper word routing");
    rd_check(1, 32'h0020_1302, "R11 R2 upper word readback");

    pins[5:4] = 2'b11;
    tick(3);
    push(6'h11, "R3 R8 upper pins");

    tick(4);
    done = 1;
    summary();
    $finish;
  end
endmodule